// File: doc/BRIEF.md
# Indirect Pointer/Data Configuration Bank

This block holds the per-channel configuration of a two-channel disk-interface controller. It is reached through two host-visible ports. An 8-bit pointer register picks a channel bank and a register index, and it also carries three bus-interface control bits and an auto-step flag. A 16-bit data port then reads or writes the register that the pointer addresses. Each channel bank has seven registers: two address bases, a general control byte, two write-only bytes that set a read-ahead count and read-ahead options, and two timing bytes.

When the auto-step flag is set, the index field of the pointer advances after every data-port access, so one pointer write can be followed by a burst of data accesses. The index steps from 6 back to 0. Every register value is driven out continuously to the rest of the controller. A write that sets the FIFO-clear option produces a single-cycle clear strobe for the addressed channel.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the pointer reads 0x50. Pointer bit 5 (burst disable) is write-only and always reads 0. All other pointer bits read back as last written.
- R2: Pointer bit 3 selects the bank (0 primary, 1 secondary) and bits 2..0 select the index. A data-port write changes only the addressed register of the addressed bank.
- R3: Index 0 (command base) resets to 0x01F0 on the primary bank and 0x0170 on the secondary bank. Index 4 (control base) resets to 0x03F6 and 0x0376 respectively. Both are full 16-bit registers.
- R4: Index 5 (data-port timing) resets to 0xF5 and index 6 (command/control timing) resets to 0xDE on both banks.
- R5: Index 1 resets to 0x01. It stores bits 7,6,5,4,3,1,0. Bit 2 is not stored and reads 0.
- R6: Indexes 2 and 3 are write-only and read 0. The read-ahead count output is {index3[1:0], index2[7:0]}. Index 3 bit 7 drives the read-ahead enable and index 3 bit 4 drives the mode-4 timing enable. All of these are 0 after reset.
- R7: A write to index 3 with bit 6 set raises that bank's FIFO-clear output for exactly the one cycle after the write. Bit 6 is not stored.
- R8: With pointer bit 7 set, each data-port read or write advances the index by one, and index 6 (or 7) steps to 0.
- R9: With pointer bit 7 clear, data-port accesses leave the pointer unchanged.
- R10: Index 7 reads 0, and a write to it changes no output.
- R11: When a pointer write and a data-port access fall in the same cycle, the access uses the old pointer and the pointer takes the written value with no auto-step.
- R12: Byte-wide registers (indexes 1, 5, 6) ignore data bits 15..8 and read them as 0.
- R13: The posted-write wait-state, burst-disable and medium-select outputs follow pointer bits 6, 5 and 4. After reset they are 1, 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_we | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 8 | Pointer write value |
| ptr_rdata | output | 8 | Pointer read view (bit 5 reads 0) |
| dat_we | input | 1 | Data-port write strobe |
| dat_re | input | 1 | Data-port read strobe (advances index when auto-step is on) |
| dat_wdata | input | 16 | Data-port write value |
| dat_rdata | output | 16 | Addressed register value, combinational from the pointer |
| posted_ws | output | 1 | One-wait-state posted write select |
| burst_off | output | 1 | Master burst disable |
| devsel_med | output | 1 | Medium decode timing select |
| cmd_base | output | 32 | Command base per bank (bank n at [16n+15:16n]) |
| ctl_base | output | 32 | Control base per bank |
| gen_cfg | output | 16 | General control byte per bank |
| ra_count | output | 20 | Read-ahead count per bank (10 bits each) |
| ra_enable | output | 2 | Read-ahead enable per bank |
| mode4_en | output | 2 | Mode-4 timing enable per bank |
| fifo_clr | output | 2 | One-cycle FIFO clear strobe per bank |
| dport_tim | output | 16 | Data-port timing byte per bank |
| cport_tim | output | 16 | Command/control timing byte per bank |

## Verification
Two functions can fall in the same cycle: a pointer write and a data-port access that would also auto-step the pointer. The bench forces this by asserting the pointer strobe and the data write strobe together while auto-step is on and the index is at 6. It then checks two things. The data lands in the register named by the old pointer. The pointer holds exactly the written value, with no step applied. A second case pairs a read with a pointer write and checks that the returned word comes from the old address.

// File: rtl/cfgbank_pkg.sv
// Shared constants and types for the pointer/data configuration bank.
// Assumes two banks selected by a single pointer bit.
package cfgbank_pkg;
    localparam int PTR_W   = 8;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 3;
    localparam int IDX_LAST = 6;
    localparam int CHAN_W  = 1;
    localparam int NCH     = 1 << CHAN_W;
    localparam int RA_HI_W = 2;
    localparam int RA_W    = BYTE_W + RA_HI_W;

    // Pointer bit positions: the host software encodes these.
    localparam int P_AUTO   = 7;
    localparam int P_WS     = 6;
    localparam int P_BURST  = 5;
    localparam int P_DEVSEL = 4;
    localparam int P_CHAN   = 3;

    // Index-3 option bit positions.
    localparam int RA_EN_BIT  = 7;
    localparam int RA_CLR_BIT = 6;
    localparam int RA_M4_BIT  = 4;

    localparam logic [PTR_W-1:0]  PTR_RST  = 8'h50;
    localparam logic [PTR_W-1:0]  PTR_RMASK = 8'hDF;
    localparam logic [BYTE_W-1:0] GEN_RST  = 8'h01;
    localparam logic [BYTE_W-1:0] GEN_MASK = 8'hFB;
    localparam logic [BYTE_W-1:0] DTIM_RST = 8'hF5;
    localparam logic [BYTE_W-1:0] CTIM_RST = 8'hDE;

    typedef enum logic [IDX_W-1:0] {
        IX_CMD  = 3'd0,
        IX_GEN  = 3'd1,
        IX_RALO = 3'd2,
        IX_RAHI = 3'd3,
        IX_CTL  = 3'd4,
        IX_DTIM = 3'd5,
        IX_CTIM = 3'd6,
        IX_NONE = 3'd7
    } idx_e;

    // Command base default for a bank.
    function automatic logic [DATA_W-1:0] cmd_rst(input int ch);
        return (ch == 0) ? 16'h01F0 : 16'h0170;
    endfunction

    // Control base default for a bank.
    function automatic logic [DATA_W-1:0] ctl_rst(input int ch);
        return (ch == 0) ? 16'h03F6 : 16'h0376;
    endfunction
endpackage

// File: rtl/cfgbank_ptr.sv
// Pointer register with index auto-step.
// A pointer write always wins over an auto-step in the same cycle.
// Assumes 'access' is high for any data-port read or write.
module cfgbank_ptr
    import cfgbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] wdata,
    input  logic             access,
    output logic [PTR_W-1:0] ptr_q
);
    logic [IDX_W-1:0] idx_next;

    // Next index after an auto-step, wrapping past the last index.
    always_comb begin
        if (ptr_q[IDX_W-1:0] >= IDX_W'(IDX_LAST))
            idx_next = '0;
        else
            idx_next = ptr_q[IDX_W-1:0] + 1'b1;
    end

    // Pointer state: load, auto-step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= PTR_RST;
        else if (we)
            ptr_q <= wdata;
        else if (access && ptr_q[P_AUTO])
            ptr_q[IDX_W-1:0] <= idx_next;
    end
endmodule

// File: rtl/cfgbank_chan.sv
// One channel bank of seven configuration registers.
// Writes land only when 'sel' is high. Indexes 2, 3 and 7 read as zero.
// Index 3 bit 6 yields a registered one-cycle FIFO clear strobe.
module cfgbank_chan
    import cfgbank_pkg::*;
#(
    parameter logic [DATA_W-1:0] CMD_RST = 16'h01F0,
    parameter logic [DATA_W-1:0] CTL_RST = 16'h03F6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cmd_base,
    output logic [DATA_W-1:0] ctl_base,
    output logic [BYTE_W-1:0] gen_cfg,
    output logic [RA_W-1:0]   ra_count,
    output logic              ra_enable,
    output logic              mode4_en,
    output logic              fifo_clr,
    output logic [BYTE_W-1:0] dport_tim,
    output logic [BYTE_W-1:0] cport_tim
);
    logic              hit;
    logic [BYTE_W-1:0] ra_lo;
    logic [RA_HI_W-1:0] ra_hi;
    idx_e              ix;

    assign hit = sel && we;
    assign ix  = idx_e'(idx);
    assign ra_count = {ra_hi, ra_lo};

    // Register writes for the addressed index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_base  <= CMD_RST;
            ctl_base  <= CTL_RST;
            gen_cfg   <= GEN_RST;
            ra_lo     <= '0;
            ra_hi     <= '0;
            ra_enable <= 1'b0;
            mode4_en  <= 1'b0;
            dport_tim <= DTIM_RST;
            cport_tim <= CTIM_RST;
        end else if (hit) begin
            case (ix)
                IX_CMD:  cmd_base  <= wdata;
                IX_GEN:  gen_cfg   <= wdata[BYTE_W-1:0] & GEN_MASK;
                IX_RALO: ra_lo     <= wdata[BYTE_W-1:0];
                IX_RAHI: begin
                    ra_hi     <= wdata[RA_HI_W-1:0];
                    ra_enable <= wdata[RA_EN_BIT];
                    mode4_en  <= wdata[RA_M4_BIT];
                end
                IX_CTL:  ctl_base  <= wdata;
                IX_DTIM: dport_tim <= wdata[BYTE_W-1:0];
                IX_CTIM: cport_tim <= wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

    // FIFO clear strobe: high for one cycle after a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fifo_clr <= 1'b0;
        else
            fifo_clr <= hit && (ix == IX_RAHI) && wdata[RA_CLR_BIT];
    end

    // Read view of the addressed index.
    always_comb begin
        case (ix)
            IX_CMD:  rdata = cmd_base;
            IX_GEN:  rdata = {{(DATA_W-BYTE_W){1'b0}}, gen_cfg};
            IX_CTL:  rdata = ctl_base;
            IX_DTIM: rdata = {{(DATA_W-BYTE_W){1'b0}}, dport_tim};
            IX_CTIM: rdata = {{(DATA_W-BYTE_W){1'b0}}, cport_tim};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgbank_top.sv
// Top of the pointer/data configuration bank.
// The pointer selects the bank and index. Data-port reads are combinational.
// Assumes the host never needs the write-only pointer bit 5 read back.
module cfgbank_top
    import cfgbank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ptr_we,
    input  logic [PTR_W-1:0]         ptr_wdata,
    output logic [PTR_W-1:0]         ptr_rdata,
    input  logic                     dat_we,
    input  logic                     dat_re,
    input  logic [DATA_W-1:0]        dat_wdata,
    output logic [DATA_W-1:0]        dat_rdata,
    output logic                     posted_ws,
    output logic                     burst_off,
    output logic                     devsel_med,
    output logic [NCH*DATA_W-1:0]    cmd_base,
    output logic [NCH*DATA_W-1:0]    ctl_base,
    output logic [NCH*BYTE_W-1:0]    gen_cfg,
    output logic [NCH*RA_W-1:0]      ra_count,
    output logic [NCH-1:0]           ra_enable,
    output logic [NCH-1:0]           mode4_en,
    output logic [NCH-1:0]           fifo_clr,
    output logic [NCH*BYTE_W-1:0]    dport_tim,
    output logic [NCH*BYTE_W-1:0]    cport_tim
);
    logic [PTR_W-1:0]  ptr_q;
    logic [CHAN_W-1:0] chan;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] chan_rd [NCH];

    cfgbank_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ptr_we),
        .wdata  (ptr_wdata),
        .access (dat_we || dat_re),
        .ptr_q  (ptr_q)
    );

    assign chan       = ptr_q[P_CHAN -: CHAN_W];
    assign idx        = ptr_q[IDX_W-1:0];
    assign ptr_rdata  = ptr_q & PTR_RMASK;
    assign posted_ws  = ptr_q[P_WS];
    assign burst_off  = ptr_q[P_BURST];
    assign devsel_med = ptr_q[P_DEVSEL];
    assign dat_rdata  = chan_rd[chan];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        cfgbank_chan #(
            .CMD_RST (cmd_rst(ch)),
            .CTL_RST (ctl_rst(ch))
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (chan == CHAN_W'(ch)),
            .we        (dat_we),
            .idx       (idx),
            .wdata     (dat_wdata),
            .rdata     (chan_rd[ch]),
            .cmd_base  (cmd_base[ch*DATA_W +: DATA_W]),
            .ctl_base  (ctl_base[ch*DATA_W +: DATA_W]),
            .gen_cfg   (gen_cfg[ch*BYTE_W +: BYTE_W]),
            .ra_count  (ra_count[ch*RA_W +: RA_W]),
            .ra_enable (ra_enable[ch]),
            .mode4_en  (mode4_en[ch]),
            .fifo_clr  (fifo_clr[ch]),
            .dport_tim (dport_tim[ch*BYTE_W +: BYTE_W]),
            .cport_tim (cport_tim[ch*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/cfgbank_chk.sv
// Property checker for the configuration bank, bound to the top module.
// Sees only the port-level signals.
module cfgbank_chk
    import cfgbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_we,
    input logic [PTR_W-1:0]  ptr_wdata,
    input logic [PTR_W-1:0]  ptr_rdata,
    input logic              dat_we,
    input logic              dat_re,
    input logic [DATA_W-1:0] dat_rdata,
    input logic [NCH-1:0]    fifo_clr
);
    // R1
    burst_bit_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rdata[P_BURST] == 1'b0);

    // R7
    fifo_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr != '0) |=> ((fifo_clr & $past(fifo_clr)) == '0));

    // R7
    fifo_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dat_we) == 1'b0) |-> (fifo_clr == '0));

    // R8
    auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && (dat_we || dat_re) && ptr_rdata[P_AUTO]
         && ptr_rdata[IDX_W-1:0] < IDX_W'(IDX_LAST))
        |=> (ptr_rdata[IDX_W-1:0] == IDX_W'($past(ptr_rdata[IDX_W-1:0]) + 1'b1)));

    // R8
    auto_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && (dat_we || dat_re) && ptr_rdata[P_AUTO]
         && ptr_rdata[IDX_W-1:0] >= IDX_W'(IDX_LAST))
        |=> (ptr_rdata[IDX_W-1:0] == '0));

    // R9
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && !ptr_rdata[P_AUTO]) |=> $stable(ptr_rdata));

    // R10
    idx7_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_rdata[IDX_W-1:0] == IX_NONE) |-> (dat_rdata == '0));

    // R11
    ptr_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> (ptr_rdata == ($past(ptr_wdata) & PTR_RMASK)));
endmodule

bind cfgbank_top cfgbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_we    (ptr_we),
    .ptr_wdata (ptr_wdata),
    .ptr_rdata (ptr_rdata),
    .dat_we    (dat_we),
    .dat_re    (dat_re),
    .dat_rdata (dat_rdata),
    .fifo_clr  (fifo_clr)
);

// File: tb/cfgbank_top_test.sv
`timescale 1ns/1ps
module cfgbank_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_we = 1'b0;
    logic [7:0]  ptr_wdata = '0;
    logic [7:0]  ptr_rdata;
    logic        dat_we = 1'b0;
    logic        dat_re = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic [15:0] dat_rdata;
    logic        posted_ws, burst_off, devsel_med;
    logic [31:0] cmd_base, ctl_base;
    logic [15:0] gen_cfg, dport_tim, cport_tim;
    logic [19:0] ra_count;
    logic [1:0]  ra_enable, mode4_en, fifo_clr;

    int n_checks = 0;
    int n_fail = 0;

    // Reference model state.
    int m_ptr;
    int m_reg [2][8];      // stored values per bank/index (index 3 holds options)
    int m_clr [2];

    always #5 clk = ~clk;

    cfgbank_top uut (
        .clk(clk), .rst_n(rst_n),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
        .dat_we(dat_we), .dat_re(dat_re), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .posted_ws(posted_ws), .burst_off(burst_off), .devsel_med(devsel_med),
        .cmd_base(cmd_base), .ctl_base(ctl_base), .gen_cfg(gen_cfg),
        .ra_count(ra_count), .ra_enable(ra_enable), .mode4_en(mode4_en),
        .fifo_clr(fifo_clr), .dport_tim(dport_tim), .cport_tim(cport_tim)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ptr = 'h50;
        for (int c = 0; c < 2; c++) begin
            m_reg[c][0] = (c == 0) ? 'h01F0 : 'h0170;
            m_reg[c][1] = 'h01;
            m_reg[c][2] = 0;
            m_reg[c][3] = 0;
            m_reg[c][4] = (c == 0) ? 'h03F6 : 'h0376;
            m_reg[c][5] = 'hF5;
            m_reg[c][6] = 'hDE;
            m_reg[c][7] = 0;
            m_clr[c] = 0;
        end
    endtask

    function automatic int model_read();
        int c = (m_ptr >> 3) & 1;
        int i = m_ptr & 7;
        if (i == 0 || i == 1 || i == 4 || i == 5 || i == 6) return m_reg[c][i];
        return 0;
    endfunction

    // Compare every output with the model.
    task automatic compare_all();
        chk("R1", "pointer", ptr_rdata, m_ptr & 'hDF);
        chk("R13", "posted_ws", posted_ws, (m_ptr >> 6) & 1);
        chk("R13", "burst_off", burst_off, (m_ptr >> 5) & 1);
        chk("R13", "devsel_med", devsel_med, (m_ptr >> 4) & 1);
        for (int c = 0; c < 2; c++) begin
            chk("R3", $sformatf("cmd_base[%0d]", c), cmd_base[c*16 +: 16], m_reg[c][0]);
            chk("R3", $sformatf("ctl_base[%0d]", c), ctl_base[c*16 +: 16], m_reg[c][4]);
            chk("R5", $sformatf("gen_cfg[%0d]", c), gen_cfg[c*8 +: 8], m_reg[c][1]);
            chk("R6", $sformatf("ra_count[%0d]", c), ra_count[c*10 +: 10],
                ((m_reg[c][3] & 3) << 8) | m_reg[c][2]);
            chk("R6", $sformatf("ra_enable[%0d]", c), ra_enable[c], (m_reg[c][3] >> 7) & 1);
            chk("R6", $sformatf("mode4_en[%0d]", c), mode4_en[c], (m_reg[c][3] >> 4) & 1);
            chk("R4", $sformatf("dport_tim[%0d]", c), dport_tim[c*8 +: 8], m_reg[c][5]);
            chk("R4", $sformatf("cport_tim[%0d]", c), cport_tim[c*8 +: 8], m_reg[c][6]);
            chk("R7", $sformatf("fifo_clr[%0d]", c), fifo_clr[c], m_clr[c]);
        end
    endtask

    // One clock of stimulus, starting at a falling edge.
    task automatic step(input bit pw, input int pd, input bit dw, input bit dr,
                        input int dd, input string req);
        int c, i;
        ptr_we = pw; ptr_wdata = pd[7:0];
        dat_we = dw; dat_re = dr; dat_wdata = dd[15:0];
        #1;
        if (dw || dr) chk(req, "data read view", dat_rdata, model_read());
        c = (m_ptr >> 3) & 1;
        i = m_ptr & 7;
        m_clr[0] = 0; m_clr[1] = 0;
        if (dw) begin
            case (i)
                0, 4: m_reg[c][i] = dd & 'hFFFF;
                1: m_reg[c][i] = dd & 'hFB;
                2, 5, 6: m_reg[c][i] = dd & 'hFF;
                3: begin
                    m_reg[c][3] = dd & 'h93;
                    if ((dd >> 6) & 1) m_clr[c] = 1;
                end
                default: ;
            endcase
        end
        if (pw) m_ptr = pd & 'hFF;
        else if ((dw || dr) && ((m_ptr >> 7) & 1))
            m_ptr = (m_ptr & 'hF8) | ((i >= 6) ? 0 : i + 1);
        @(negedge clk);
        ptr_we = 0; dat_we = 0; dat_re = 0;
        compare_all();
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();                                   // R1 R3 R4 R5 R6 R13 reset state

        // R8: auto-step reads over bank 0, wrap from 6 to 0
        step(1, 'hD0, 0, 0, 0, "R2");
        for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 0, "R8");
        // Bank 1 defaults through the data port
        step(1, 'hD8, 0, 0, 0, "R2");
        for (int k = 0; k < 7; k++) step(0, 0, 0, 1, 0, "R3");

        // R12 / R2: write every index of bank 0 with auto-step
        step(1, 'hD0, 0, 0, 0, "R2");
        step(0, 0, 1, 0, 'h1234, "R2");
        step(0, 0, 1, 0, 'hFFFF, "R5");
        step(0, 0, 1, 0, 'h003C, "R6");
        step(0, 0, 1, 0, 'h00D3, "R7");
        step(0, 0, 0, 0, 0, "R7");                       // R7 strobe gone after one cycle
        step(0, 0, 1, 0, 'hABCD, "R2");
        step(0, 0, 1, 0, 'hAA55, "R12");
        step(0, 0, 1, 0, 'h7766, "R12");
        step(1, 'hD0, 0, 0, 0, "R2");
        for (int k = 0; k < 7; k++) step(0, 0, 0, 1, 0, "R6");

        // R9: no auto-step, bank 1 index 5, other control bits cleared
        step(1, 'h0D, 0, 0, 0, "R13");
        step(0, 0, 1, 0, 'h0011, "R9");
        step(0, 0, 1, 0, 'h0022, "R9");
        step(0, 0, 0, 1, 0, "R9");

        // R10: index 7 ignores writes, reads zero, steps to 0
        step(1, 'h8F, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, "R10");
        step(1, 'h8F, 0, 0, 0, "R10");
        step(0, 0, 1, 0, 'hFFFF, "R10");

        // R11: pointer write together with a data write at index 6
        step(1, 'h86, 0, 0, 0, "R11");
        step(1, 'h01, 1, 0, 'h0042, "R11");
        // R11: pointer write together with a read; read uses old address
        step(1, 'h8C, 1, 0, 'h0F0F, "R11");
        step(1, 'h80, 0, 1, 0, "R11");

        // R7: clear strobe on bank 1 without touching the stored options
        step(1, 'h8B, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 'h0040, "R7");
        step(0, 0, 0, 0, 0, "R7");

        // R1 / R13: burst-disable bit is write-only
        step(1, 'h20, 0, 0, 0, "R1");
        step(1, 'hFF, 0, 0, 0, "R1");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule